// File: doc/BRIEF.md
# Programmable Codec Clock Generator

This block turns a single master clock into the timing strobes a serial codec port needs. It produces a bit-clock enable, an active-low frame-sync and two carrier strobes. Every output is a one-cycle enable or a level in the master-clock domain, so downstream logic stays synchronous. The bit period is R master cycles. The frame period comes from a cascade of three dividers (M, Q, OVER). A mode input can force M and Q to pass-through, which leaves only OVER. A second mode input selects the frame source. In master mode the cascade generates frame-sync. In slave mode the internal frame is restarted by every falling edge of an external frame-sync, and the cascade output is ignored.

A free-running carrier divider F gives the carrier strobe. A further divider N, clocked by the carrier strobe, gives the auxiliary carrier. Divider values and the bypass mode are copied into shadow registers only at a frame boundary. A new setting therefore never cuts a frame or a bit short.

The frame controller is a four-state machine:
- LOAD is entered from reset. In master mode it moves to SYNC. In slave mode it moves to WAIT.
- WAIT holds until an external falling edge moves it to SYNC.
- SYNC drives frame-sync low. At the end of the first bit period it moves to FRAME.
- FRAME holds.

A frame start moves any state to SYNC. A frame start is either the cascade terminal count in master mode or an external falling edge in slave mode.

Top module: `codec_clkgen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, frame-sync is high and the bit, carrier and auxiliary strobes are low.
- R2: The bit strobe fires once every R master cycles. It is aligned so that its first pulse in a frame comes R-1 cycles after the cycle in which frame-sync is first seen low.
- R3: With the bypass-mode input at 0 and the master input at 1, frame-sync falls every OVER master cycles. The first fall is one cycle after reset is released.
- R4: With the bypass-mode input at 1 and the master input at 1, frame-sync falls every M·Q·OVER master cycles.
- R5: Frame-sync stays low for exactly R master cycles (one bit period) from each fall.
- R6: With the master input at 0, frame-sync falls exactly one master cycle after each falling edge of the external frame-sync input. The internal frame divider causes no fall.
- R7: The carrier strobe fires every F master cycles. The auxiliary strobe fires every F·N master cycles and only in a cycle that also has a carrier strobe.
- R8: Divider values and the bypass mode are taken only at a frame start. A change made mid-frame first takes effect in the frame that follows.
- R9: A divider value of 0 or 1 passes its input through, so the stage fires on every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: generate frame-sync; 0: follow external frame-sync |
| mcm_i | input | 1 | 1: M and Q stages active; 0: M and Q bypassed |
| fs_ext_n_i | input | 1 | External active-low frame-sync, synchronous to clk |
| div_r_i | input | DW | Bit-period divider R |
| div_m_i | input | DW | First cascade divider M |
| div_q_i | input | DW | Second cascade divider Q |
| div_over_i | input | DW | Oversampling divider OVER |
| div_f0_i | input | DW | Carrier divider F |
| div_aux_i | input | DW | Auxiliary carrier divider N |
| bit_stb_o | output | 1 | One-cycle bit-clock enable |
| fs_n_o | output | 1 | Active-low frame-sync, low for one bit period |
| f0_stb_o | output | 1 | One-cycle carrier strobe |
| aux_stb_o | output | 1 | One-cycle auxiliary carrier strobe |

## Verification
Suppose a cascade counter is corrupted or misses its restart. Frame-sync then falls a few cycles early or late, and the scoreboard sees this at the very next expected fall, at most one frame later. If the bit counter fails to restart at a frame start, the next bit strobe lands off the R grid within one bit period of that fall. Stale or early-loaded shadow values move either the next fall or the width of the low pulse, so the mismatch appears in the frame right after a reconfiguration. Wrong state-machine sequencing shows as a low pulse longer or shorter than R cycles, or as a frame-sync fall that the scoreboard does not expect.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SYNC  = 2'd2,
        ST_FRAME = 2'd3
    } ccg_state_e;

    // cascade of frame-rate stages: M, Q, OVER
    localparam int NSTAGE = 3;
endpackage

// File: rtl/ccg_div.sv
`timescale 1ns/1ps
module ccg_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         restart,
    input  logic [W-1:0] val,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic         wrap;

    // value 0 or 1 acts as pass-through; >= tolerates a shrinking value
    assign wrap = (val <= W'(1)) || (cnt >= val - W'(1));
    assign tick = en && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= wrap ? '0 : cnt + W'(1);
        end
    end

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && val > W'(1)) |=> !tick || !en || (val <= W'(1))) else $error("restart"); // R2
endmodule

// File: rtl/ccg_fsm.sv
`timescale 1ns/1ps
module ccg_fsm
    import ccg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic over_tick,
    input  logic ext_fall,
    input  logic bit_tick,
    output logic frame_start,
    output logic load,
    output logic run,
    output logic fs_n
);
    ccg_state_e state, nxt;

    assign frame_start = ((state == ST_LOAD) && master) || (master ? over_tick : ext_fall);
    assign load        = frame_start || (state == ST_LOAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (frame_start) begin
            nxt = ST_SYNC;
        end else begin
            unique case (state)
                ST_LOAD:  nxt = ST_WAIT;
                ST_WAIT:  nxt = ST_WAIT;
                ST_SYNC:  nxt = bit_tick ? ST_FRAME : ST_SYNC;
                ST_FRAME: nxt = ST_FRAME;
            endcase
        end
    end

    always_comb begin
        fs_n = (state != ST_SYNC);
        run  = (state != ST_LOAD);
    end

    AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && bit_tick && !frame_start) |=> fs_n) else $error("sync"); // R5
    AST_FALL_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fs_n) |-> $past(frame_start)) else $error("fall"); // R3
endmodule

// File: rtl/codec_clkgen.sv
`timescale 1ns/1ps
module codec_clkgen
    import ccg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_i,
    input  logic          mcm_i,
    input  logic          fs_ext_n_i,
    input  logic [DW-1:0] div_r_i,
    input  logic [DW-1:0] div_m_i,
    input  logic [DW-1:0] div_q_i,
    input  logic [DW-1:0] div_over_i,
    input  logic [DW-1:0] div_f0_i,
    input  logic [DW-1:0] div_aux_i,
    output logic          bit_stb_o,
    output logic          fs_n_o,
    output logic          f0_stb_o,
    output logic          aux_stb_o
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic          frame_start, load, run, ext_q, ext_fall, bit_tick, f0_tick;
    logic [DW-1:0] r_sh, m_sh, q_sh, over_sh, f_sh, n_sh;
    logic          mcm_sh;
    logic [DW-1:0] stage_val  [NSTAGE];
    logic          stage_en   [NSTAGE];
    logic          stage_tick [NSTAGE];

    // shadow copies: updated only at a frame boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_sh <= ONE; m_sh <= ONE; q_sh <= ONE; over_sh <= ONE;
            f_sh <= ONE; n_sh <= ONE; mcm_sh <= 1'b0;
        end else if (load) begin
            r_sh <= div_r_i; m_sh <= div_m_i; q_sh <= div_q_i; over_sh <= div_over_i;
            f_sh <= div_f0_i; n_sh <= div_aux_i; mcm_sh <= mcm_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b1;
        else        ext_q <= fs_ext_n_i;
    end
    assign ext_fall = ext_q && !fs_ext_n_i;

    assign stage_val[0] = mcm_sh ? m_sh : ONE;
    assign stage_val[1] = mcm_sh ? q_sh : ONE;
    assign stage_val[2] = over_sh;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stage_en[g] = run;
        end else begin : g_link
            assign stage_en[g] = stage_tick[g-1];
        end
        ccg_div #(.W(DW)) u_div (
            .clk(clk), .rst_n(rst_n), .en(stage_en[g]), .restart(frame_start),
            .val(stage_val[g]), .tick(stage_tick[g])
        );
    end

    ccg_div #(.W(DW)) u_bit (
        .clk(clk), .rst_n(rst_n), .en(run), .restart(frame_start),
        .val(r_sh), .tick(bit_tick)
    );

    ccg_div #(.W(DW)) u_f0 (
        .clk(clk), .rst_n(rst_n), .en(run), .restart(1'b0),
        .val(f_sh), .tick(f0_tick)
    );

    ccg_div #(.W(DW)) u_aux (
        .clk(clk), .rst_n(rst_n), .en(f0_tick), .restart(1'b0),
        .val(n_sh), .tick(aux_stb_o)
    );

    ccg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .master(master_i), .over_tick(stage_tick[NSTAGE-1]),
        .ext_fall(ext_fall), .bit_tick(bit_tick), .frame_start(frame_start),
        .load(load), .run(run), .fs_n(fs_n_o)
    );

    assign bit_stb_o = bit_tick;
    assign f0_stb_o  = f0_tick;

    AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && ext_fall) |=> !fs_n_o) else $error("slave"); // R6
    AST_AUX_WITH_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        aux_stb_o |-> f0_stb_o) else $error("aux"); // R7
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(r_sh) && $stable(over_sh) && $stable(mcm_sh))) else $error("shadow"); // R8
endmodule

// File: tb/codec_clkgen_bench.sv
`timescale 1ns/1ps
module codec_clkgen_bench;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n, master, mcm, fs_ext_n;
    logic [DW-1:0] dr, dm, dq, dover, df, dn;
    logic bit_stb, fs_n, f0_stb, aux_stb;

    always #2 clk = ~clk;

    codec_clkgen #(.DW(DW)) u_codec_clkgen (
        .clk(clk), .rst_n(rst_n), .master_i(master), .mcm_i(mcm), .fs_ext_n_i(fs_ext_n),
        .div_r_i(dr), .div_m_i(dm), .div_q_i(dq), .div_over_i(dover),
        .div_f0_i(df), .div_aux_i(dn),
        .bit_stb_o(bit_stb), .fs_n_o(fs_n), .f0_stb_o(f0_stb), .aux_stb_o(aux_stb)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    int exp_q[$];
    int last_fall = 0, falls_seen = 0, r_cur = 4, r_next = 4;
    string cur_tag = "R3";
    bit prev_fs = 1'b1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor: pops expected frame-sync falls, checks pulse width and bit grid
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_fs && !fs_n) begin
                if (exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, cur_tag, cyc, e);
                end else begin
                    check(1'b0, "R6 unexpected frame-sync fall", cyc, -1);
                end
                last_fall = cyc;
                r_cur = r_next;
                falls_seen++;
            end
            if (!prev_fs && fs_n)
                check(cyc - last_fall == r_cur, "R5 low width", cyc - last_fall, r_cur);
            if (bit_stb && falls_seen > 0)
                check((cyc - last_fall) % r_cur == r_cur - 1, "R2 bit strobe phase",
                      (cyc - last_fall) % r_cur, r_cur - 1);
            prev_fs = fs_n;
        end
    end

    task automatic gap_of(output int g, input bit use_aux);
        int t;
        do @(negedge clk); while (!(use_aux ? aux_stb : f0_stb));
        t = cyc;
        do @(negedge clk); while (!(use_aux ? aux_stb : f0_stb));
        g = cyc - t;
    endtask

    // driver: pushes expected falls for k frames, optionally measures carriers
    task automatic run_frames(input int p_first, input int p, input int k,
                              input int fexp, input int aexp);
        int base, start, g;
        base = last_fall;
        start = falls_seen;
        for (int i = 0; i < k; i++) exp_q.push_back(base + p_first + p * i);
        if (fexp > 0) begin
            wait (falls_seen >= start + 1);
            gap_of(g, 1'b0);
            check(g == fexp, "R7 carrier period", g, fexp);
            gap_of(g, 1'b1);
            check(g == aexp, "R7 aux period", g, aexp);
        end
        wait (falls_seen == start + k);
    endtask

    task automatic ext_frame(input int gap);
        repeat (gap - 1) @(negedge clk);
        fs_ext_n = 1'b0;
        exp_q.push_back(cyc + 1);
        @(negedge clk);
        fs_ext_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; master = 1'b1; mcm = 1'b0; fs_ext_n = 1'b1;
        dr = 8'd4; dm = 8'd2; dq = 8'd3; dover = 8'd16; df = 8'd3; dn = 8'd2;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(fs_n == 1'b1, "R1 fs_n in reset", fs_n, 1);
        check(bit_stb == 1'b0, "R1 bit strobe in reset", bit_stb, 0);
        check(f0_stb == 1'b0, "R1 carrier in reset", f0_stb, 0);
        check(aux_stb == 1'b0, "R1 aux in reset", aux_stb, 0);
        exp_q.push_back(cyc + 1);
        rst_n = 1'b1;
        #1;
        check(fs_n == 1'b1 && bit_stb == 1'b0, "R1 load cycle", fs_n, 1);
        wait (falls_seen == 1);

        // R3: bypass, period OVER = 16; R7: F=3, N=2
        cur_tag = "R3 frame period";
        run_frames(16, 16, 4, 3, 6);

        // R4 and R8: enable cascade mid-frame; current frame keeps 16
        mcm = 1'b1; dover = 8'd4;
        cur_tag = "R4/R8 frame period";
        run_frames(16, 24, 3, 0, 0);

        // R8: new bit period at next boundary
        dr = 8'd2; r_next = 2;
        cur_tag = "R8 frame period";
        run_frames(24, 24, 2, 0, 0);

        // R9: pass-through dividers
        dr = 8'd1; r_next = 1; mcm = 1'b0; dover = 8'd5; df = 8'd1; dn = 8'd0;
        cur_tag = "R9 frame period";
        run_frames(24, 5, 4, 1, 1);

        // R6: slave mode follows external falls
        master = 1'b0; dr = 8'd4; r_next = 4;
        cur_tag = "R6 slave fall";
        ext_frame(12);
        ext_frame(12);
        ext_frame(7);
        ext_frame(20);
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R6 pending falls", exp_q.size(), 0);
        check(falls_seen == 18, "R6 fall count", falls_seen, 18);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #80000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule